// File: doc/BRIEF.md
# Adaptive Binary Arithmetic Decoder

This block turns a serial arithmetic-coded tag back into the binary symbol stream it was made from. It holds a 16-bit interval (low and high bounds) and a 16-bit code window, plus an adaptive pair of counts for zeros and ones. For each symbol it works out where the adaptive split point falls inside the current interval. It then emits 0 when the code window sits below the split and 1 otherwise. After each decision it narrows the interval, updates the counts, and renormalizes one bit position per clock.

No probability table travels with the data. The decoder grows its model from the symbols it has already produced, using the same counting and halving rule as the matching encoder. A decode run begins only when the start trigger is seen, and it lasts for a programmed number of symbols. Code bits arrive serially on a valid/ready handshake. A separate end-of-stream input lets the decoder fill zeros once the sender has nothing left. When the run is complete, `done` rises and the block stays quiet until the next trigger.

Top module: `adaptive_bin_decoder`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, `code_ready`, `out_valid` and `done` are all 0.
- R2: Before the first start pulse, no code bit is accepted (`code_ready` stays 0) whatever `code_valid` does.
- R3: After a start pulse with a nonzero symbol count, `code_ready` is high until 16 bits have been accepted, MSB first, into the code window. The first decision appears on the cycle after the 16th accepted bit.
- R4: Each decision is a one-cycle `out_valid` pulse. `out_bit` is 0 exactly when (code − low) < split, where range = high − low + 1 and split = floor(range·c0/(c0+c1)).
- R5: A decoded 0 sets high to low + split − 1. A decoded 1 sets low to low + split.
- R6: Between decisions the interval is renormalized at one shift per cycle, and each shift takes one code bit. The three cases are: high MSB 0; low MSB 1; and low in [0x4000,0x8000) with high in [0x8000,0xC000). In the third case, bit 14 of each register is inverted as it becomes the MSB. `code_ready` is high only on cycles where a shift is pending. The decoder stalls while `code_valid` and `code_end` are both 0.
- R7: Both counts start at 1. The count of the decoded symbol is incremented after each decision. If the sum then reaches `CNT_LIMIT`, both counts are halved, rounding up.
- R8: While `code_end` is 1 and `code_valid` is 0, a pending shift takes a 0 bit without waiting.
- R9: After the programmed number of symbols has been output, `done` is 1, `code_ready` and `out_valid` stay 0, and all input except a new start is ignored. A new start restarts with a fresh model.
- R10: A start with a symbol count of 0 raises `done` on the next cycle and accepts no code bits.
- R11: Fed with a stream from the matching encoder, the decoder reproduces the encoder's source bits in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Trigger that begins a decode run (honoured when idle or done) |
| nsym | input | NSYM_W | Number of symbols to decode, sampled with start |
| code_bit | input | 1 | Serial code bit |
| code_valid | input | 1 | code_bit holds a valid bit |
| code_end | input | 1 | Sender has no more bits; missing bits are read as 0 |
| code_ready | output | 1 | Decoder accepts code_bit this cycle |
| out_bit | output | 1 | Decoded symbol |
| out_valid | output | 1 | out_bit is valid this cycle |
| done | output | 1 | Programmed symbol count has been output |

## Verification
The bench builds the decoder with `CNT_W` = 6, `CNT_LIMIT` = 24 and `NSYM_W` = 12. With a count ceiling this small, the halving step fires every few symbols, so runs of a few hundred bits walk through many rescalings. Skewed, alternating and pseudo-random sources then drive the interval through all three renormalization cases. One run adds random gaps on `code_valid` to exercise stalls. Another strips the stream's trailing zeros, so the zero-fill path on `code_end` has to supply them.

// File: rtl/adaptive_bin_decoder.sv
module adaptive_bin_decoder #(
  parameter int PREC      = 16,
  parameter int CNT_W     = 10,
  parameter int CNT_LIMIT = 1024,
  parameter int NSYM_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NSYM_W-1:0] nsym,
  input  logic              code_bit,
  input  logic              code_valid,
  input  logic              code_end,
  output logic              code_ready,
  output logic              out_bit,
  output logic              out_valid,
  output logic              done
);
  localparam int RW = PREC + 1;
  localparam int PW = PREC + 1 + CNT_W;
  localparam int LW = $clog2(PREC + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_DECIDE, S_RENORM, S_DONE} st_t;

  st_t               st;
  logic [PREC-1:0]   low, high, code;
  logic [CNT_W-1:0]  c0, c1;
  logic [NSYM_W-1:0] left;
  logic [LW-1:0]     lcnt;

  wire [RW-1:0]    range_w = {1'b0, high} - {1'b0, low} + RW'(1);
  wire [CNT_W:0]   tot     = {1'b0, c0} + {1'b0, c1};
  wire [PW-1:0]    prod    = PW'(range_w) * PW'(c0);
  wire [PW-1:0]    quot    = prod / PW'(tot);
  wire [PREC-1:0]  offs    = code - low;
  wire             sym     = PW'(offs) >= quot;
  wire [PREC-1:0]  cut     = low + quot[PREC-1:0];

  wire [CNT_W-1:0] n0   = c0 + CNT_W'(!sym);
  wire [CNT_W-1:0] n1   = c1 + CNT_W'(sym);
  wire [CNT_W:0]   ntot = {1'b0, n0} + {1'b0, n1};
  wire             halve = ntot >= (CNT_W+1)'(CNT_LIMIT);

  wire e_lo  = !high[PREC-1];
  wire e_hi  = low[PREC-1];
  wire e_mid = (low[PREC-1:PREC-2] == 2'b01) && (high[PREC-1:PREC-2] == 2'b10);
  wire need  = e_lo | e_hi | e_mid;
  wire inb   = code_valid ? code_bit : 1'b0;
  wire take  = code_ready & (code_valid | code_end);

  assign code_ready = (st == S_LOAD) || (st == S_RENORM && need);
  assign out_valid  = (st == S_DECIDE);
  assign out_bit    = sym;
  assign done       = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      low  <= '0;
      high <= '1;
      code <= '0;
      c0   <= CNT_W'(1);
      c1   <= CNT_W'(1);
      left <= '0;
      lcnt <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          low  <= '0;
          high <= '1;
          code <= '0;
          c0   <= CNT_W'(1);
          c1   <= CNT_W'(1);
          left <= nsym;
          lcnt <= '0;
          st   <= (nsym == '0) ? S_DONE : S_LOAD;
        end
        S_LOAD: if (take) begin
          code <= {code[PREC-2:0], inb};
          lcnt <= lcnt + LW'(1);
          if (lcnt == LW'(PREC - 1)) st <= S_DECIDE;
        end
        S_DECIDE: begin
          if (sym) low  <= cut;
          else     high <= cut - PREC'(1);
          if (halve) begin
            c0 <= (n0 >> 1) + CNT_W'(n0[0]);
            c1 <= (n1 >> 1) + CNT_W'(n1[0]);
          end else begin
            c0 <= n0;
            c1 <= n1;
          end
          left <= left - NSYM_W'(1);
          st   <= (left == NSYM_W'(1)) ? S_DONE : S_RENORM;
        end
        S_RENORM: begin
          if (!need) st <= S_DECIDE;
          else if (take) begin
            if (e_lo || e_hi) begin
              low  <= {low[PREC-2:0], 1'b0};
              high <= {high[PREC-2:0], 1'b1};
              code <= {code[PREC-2:0], inb};
            end else begin
              low  <= {~low[PREC-2], low[PREC-3:0], 1'b0};
              high <= {~high[PREC-2], high[PREC-3:0], 1'b1};
              code <= {~code[PREC-2], code[PREC-3:0], inb};
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module adaptive_bin_decoder_chk #(
  parameter int PREC      = 16,
  parameter int CNT_W     = 10,
  parameter int CNT_LIMIT = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             code_ready,
  input logic             out_valid,
  input logic             done,
  input logic [PREC-1:0]  low,
  input logic [PREC-1:0]  high,
  input logic [CNT_W-1:0] c0,
  input logic [CNT_W-1:0] c1
);
  p_interval_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    low <= high);

  p_count_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (c0 != '0) && (c1 != '0) && (({1'b0, c0} + {1'b0, c1}) < (CNT_W+1)'(CNT_LIMIT)));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_no_take_on_decide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !code_ready);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!code_ready && !out_valid));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

bind adaptive_bin_decoder adaptive_bin_decoder_chk #(
  .PREC(PREC), .CNT_W(CNT_W), .CNT_LIMIT(CNT_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .code_ready(code_ready),
  .out_valid(out_valid), .done(done), .low(low), .high(high), .c0(c0), .c1(c1)
);

// File: tb/tb_adaptive_bin_decoder.sv
module tb_adaptive_bin_decoder;
  localparam int LIM  = 24;
  localparam int HALF = 32768;
  localparam int QTR  = 16384;

  logic clk = 0, rst_n = 0, start = 0;
  logic [11:0] nsym = '0;
  logic code_bit = 0, code_valid = 0, code_end = 0;
  logic code_ready, out_bit, out_valid, done;

  adaptive_bin_decoder #(.PREC(16), .CNT_W(6), .CNT_LIMIT(LIM), .NSYM_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .nsym(nsym), .code_bit(code_bit),
    .code_valid(code_valid), .code_end(code_end), .code_ready(code_ready),
    .out_bit(out_bit), .out_valid(out_valid), .done(done));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit src_q[$], enc_q[$], strm[$], got[$];
  int gap_pct = 0;
  bit end_mode = 0;
  int zfill = 0, halvings = 0;

  int mst, m_low, m_high, m_code, m_c0, m_c1, m_left, m_lc;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int m_case();
    if (m_high < HALF) return 1;
    if (m_low >= HALF) return 2;
    if (m_low >= QTR && m_high < 3*QTR) return 3;
    return 0;
  endfunction

  function automatic int m_split();
    return ((m_high - m_low + 1) * m_c0) / (m_c0 + m_c1);
  endfunction

  function automatic bit m_sym();
    return (m_code - m_low) >= m_split();
  endfunction

  function automatic bit m_ready();
    return (mst == 1) || (mst == 3 && m_case() != 0);
  endfunction

  // behavioural reference, advanced every clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 0; m_low = 0; m_high = 65535; m_code = 0; m_c0 = 1; m_c1 = 1; m_left = 0; m_lc = 0;
    end else begin
      bit tk, ib, s;
      int sp, e;
      tk = m_ready() && (code_valid || code_end);
      ib = code_valid ? code_bit : 1'b0;
      if (code_ready && code_valid && strm.size() > 0) void'(strm.pop_front());
      if (code_ready && code_end && !code_valid) zfill++;
      case (mst)
        0, 4: if (start) begin
          m_low = 0; m_high = 65535; m_code = 0; m_c0 = 1; m_c1 = 1; m_lc = 0;
          m_left = nsym;
          mst = (nsym == 0) ? 4 : 1;
        end
        1: if (tk) begin
          m_code = (m_code * 2 + ib) % 65536;
          m_lc++;
          if (m_lc == 16) mst = 2;
        end
        2: begin
          sp = m_split(); s = m_sym();
          if (s) begin m_low = m_low + sp; m_c1++; end
          else begin m_high = m_low + sp - 1; m_c0++; end
          if (m_c0 + m_c1 >= LIM) begin
            m_c0 = (m_c0 + 1) / 2; m_c1 = (m_c1 + 1) / 2; halvings++;
          end
          m_left--;
          mst = (m_left == 0) ? 4 : 3;
        end
        3: begin
          e = m_case();
          if (e == 0) mst = 2;
          else if (tk) begin
            if (e == 2) begin m_low -= HALF; m_high -= HALF; m_code -= HALF; end
            if (e == 3) begin m_low -= QTR; m_high -= QTR; m_code -= QTR; end
            m_low = 2 * m_low; m_high = 2 * m_high + 1; m_code = 2 * m_code + ib;
          end
        end
        default: mst = 0;
      endcase
    end
  end

  // compare at falling edge, then drive the next input bit
  always @(negedge clk) begin
    if (rst_n) begin
      chk(code_ready == m_ready(), "R3 R6 R8 code_ready", code_ready, m_ready());
      chk(out_valid == (mst == 2), "R4 out_valid", out_valid, mst == 2);
      if (mst == 2) chk(out_bit == m_sym(), "R4 R5 R7 out_bit", out_bit, m_sym());
      chk(done == (mst == 4), "R9 R10 done", done, mst == 4);
      if (out_valid) got.push_back(out_bit);
    end
    code_valid = (strm.size() > 0) && (($urandom % 100) >= gap_pct);
    code_bit   = (strm.size() > 0) ? strm[0] : 1'b0;
    code_end   = end_mode && (strm.size() == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL R9 watchdog: actual not done expected done");
      finish_up();
    end
  end

  task automatic encode();
    int lo, hi, pend, c0, c1, r, sp;
    lo = 0; hi = 65535; pend = 0; c0 = 1; c1 = 1;
    enc_q.delete();
    foreach (src_q[i]) begin
      r = hi - lo + 1;
      sp = (r * c0) / (c0 + c1);
      if (src_q[i]) begin lo = lo + sp; c1++; end
      else begin hi = lo + sp - 1; c0++; end
      if (c0 + c1 >= LIM) begin c0 = (c0 + 1) / 2; c1 = (c1 + 1) / 2; end
      forever begin
        if (hi < HALF) begin
          enc_q.push_back(0); repeat (pend) enc_q.push_back(1); pend = 0;
        end else if (lo >= HALF) begin
          enc_q.push_back(1); repeat (pend) enc_q.push_back(0); pend = 0;
          lo -= HALF; hi -= HALF;
        end else if (lo >= QTR && hi < 3*QTR) begin
          pend++; lo -= QTR; hi -= QTR;
        end else break;
        lo = 2 * lo; hi = 2 * hi + 1;
      end
    end
    pend++;
    if (lo < QTR) begin enc_q.push_back(0); repeat (pend) enc_q.push_back(1); end
    else begin enc_q.push_back(1); repeat (pend) enc_q.push_back(0); end
  endtask

  task automatic run(input int n, input int pat, input int gap, input bit endm);
    src_q.delete();
    for (int i = 0; i < n; i++) begin
      case (pat)
        0: src_q.push_back(i % 7 == 0);
        1: src_q.push_back(($urandom % 4) == 0);
        default: src_q.push_back(i[0]);
      endcase
    end
    encode();
    if (endm) while (enc_q.size() > 0 && enc_q[$] == 1'b0) void'(enc_q.pop_back());
    else repeat (24) enc_q.push_back(1'b0);
    got.delete(); zfill = 0;
    @(negedge clk);
    strm = enc_q; gap_pct = gap; end_mode = endm; nsym = 12'(n); start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    chk(got.size() == n, "R9 symbol count at done", got.size(), n);
    for (int i = 0; i < n && i < got.size(); i++)
      chk(got[i] == src_q[i], "R11 decoded bit", got[i], src_q[i]);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!code_ready && !out_valid && !done, "R1 outputs in reset", {code_ready, out_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!code_ready && !out_valid && !done, "R1 outputs after reset", {code_ready, out_valid, done}, 0);

    // R2: bits offered before any start are not taken
    strm = '{1, 0, 1, 1, 0, 1, 0, 0};
    repeat (10) begin
      @(negedge clk);
      chk(!code_ready, "R2 ready before start", code_ready, 0);
    end
    chk(strm.size() == 8, "R2 bits untouched before start", strm.size(), 8);

    // R10: zero symbol count
    @(negedge clk);
    nsym = '0; start = 1;
    @(negedge clk);
    start = 0;
    chk(done, "R10 done after empty run", done, 1);
    chk(strm.size() == 8, "R10 no bits taken", strm.size(), 8);

    // skewed source with stalls
    run(200, 0, 30, 1'b0);

    // R9: input ignored after done
    strm = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1};
    gap_pct = 0;
    repeat (20) begin
      @(negedge clk);
      chk(!code_ready && !out_valid && done, "R9 quiet after done", {code_ready, out_valid, done}, 1);
    end
    chk(strm.size() == 12, "R9 no bits taken after done", strm.size(), 12);

    // R8 R7: random source, trailing zeros supplied by code_end
    halvings = 0;
    run(300, 1, 0, 1'b1);
    chk(zfill > 0, "R8 zero fill used", zfill, 1);
    chk(halvings > 0, "R7 count halving reached", halvings, 1);

    // alternating source, heavy stalls, fresh model on restart
    run(64, 2, 50, 1'b0);

    finish_up();
  end
endmodule